// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause 22 management frames towards an Ethernet PHY. Software sets up three values through a four-word register window: the target (PHY address, register number and direction), the 16-bit value for a write, and a control word. Setting the start bit in the control word launches one frame. The same bit then reads back as a busy flag until the frame has been clocked out. A read frame leaves the PHY's answer in a read-back register. An enable bit in the control word must be set, or no frame starts.

The management clock comes from the system clock through a divider. Its half period is `CLK_HALF` system cycles, and it stays low between frames. The data line is split into an output, an output enable and an input, so the pad tristate lives outside the block. Register writes take effect on the clock edge where `bus_wr_en` is high. The window has no handshake and no back-pressure. Software is expected to poll the busy flag before it launches the next frame.

Top module: `mdio_mgmt_top`

## Requirements
- R1: After reset, all four register words read 0, `mdc` is low and `mdio_oe` is low.
- R2: Word 0 (target) keeps bits 4:0 as the register number, bits 9:5 as the PHY address and bit 10 as the direction (1 read, 0 write). Word 1 keeps a 16-bit write value in bits 15:0. Both read back what was written.
- R3: A write to word 3 with bit 0 and bit 3 both 1 starts a frame. Word 3 reads bit 0 as 1 from the next cycle until the frame ends, and bit 3 as the stored enable.
- R4: A start write whose bit 3 is 0 starts nothing: busy stays 0 and `mdc` stays low.
- R5: A start write while a frame is running is ignored. The running frame keeps its target and length, although word 0 still takes the new value.
- R6: `mdc` has a period of 2*CLK_HALF system cycles and is low whenever no frame runs. A frame holds busy for 128*CLK_HALF cycles and has exactly 64 rising `mdc` edges.
- R7: Frame bits, MSB first, in this order: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register number, 2 turnaround bits, 16 data bits. The master changes `mdio_o` only when `mdc` falls.
- R8: In a write frame, `mdio_oe` is 1 for all 64 bits, the turnaround is 1 then 0, and the data bits are word 1 bits 15:0.
- R9: In a read frame, `mdio_oe` goes low from the first turnaround bit to the end of the frame. The 16 data bits are sampled from `mdio_i` at rising `mdc` edges and appear in word 2 bits 15:0 when busy clears. A line that nobody drives (pulled high) gives 16'hFFFF.
- R10: Word 2 changes only at the end of a read frame. A write frame leaves it unchanged, and `mdio_oe` is low between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word index for write and read (0 target, 1 write value, 2 read value, 3 control) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Sampled management data line |
| mdio_o | output | 1 | Driven management data value |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |

## Verification
The hardest case to reach is a start request that arrives in the middle of a running read frame, together with a rewrite of the target word. The frame must then finish with the original register's contents and must not gain extra clock edges. The bench launches a read, waits sixty cycles, rewrites the target and writes the start bit again. It then checks the rising-edge count, the read-back value and the target word. A behavioural PHY that answers only its own address covers the case of an undriven line and the clause 22 turnaround. A cycle model checks `mdc`, the drive enable, the driven bit and busy on every clock.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int DATA_W     = 16;
  localparam int FIELD_W    = 5;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int BUS_W      = 32;

  localparam int CTRL_GO_BIT = 0;
  localparam int CTRL_EN_BIT = 3;

  typedef enum logic [1:0] {
    WIN_TARGET = 2'd0,
    WIN_WVAL   = 2'd1,
    WIN_RVAL   = 2'd2,
    WIN_CTRL   = 2'd3
  } win_idx_e;

  // Layout of the target word: direction at bit 10, PHY at 9:5, register at 4:0
  typedef struct packed {
    logic               is_read;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regnum;
  } mdio_cmd_t;

  localparam int CMD_W = $bits(mdio_cmd_t);

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c, logic [DATA_W-1:0] wv);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] dat;
    op  = c.is_read ? 2'b10 : 2'b01;
    ta  = c.is_read ? 2'b11 : 2'b10;
    dat = c.is_read ? '0 : wv;
    return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regnum, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int CLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  logic term;

  generate
    if (CLK_HALF == 1) begin : g_direct
      assign term = run_i;
    end else begin : g_count
      localparam int CW = $clog2(CLK_HALF);
      logic [CW-1:0] cnt_q;
      assign term = run_i && (cnt_q == CW'(CLK_HALF - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !run_i || term) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  assign rise_o = term && !mdc_o;
  assign fall_o = term && mdc_o;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) mdc_o <= 1'b0;
    else if (term)        mdc_o <= ~mdc_o;
  end

  // R6: clock parked low whenever the engine is idle
  assert_mdc_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !mdc_o) else $error("mdc high while idle");
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic [DATA_W-1:0] wval_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_rd_o,
  output logic [DATA_W-1:0] cap_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int BW   = $clog2(FRAME_BITS);
  localparam int LAST = FRAME_BITS - 1;

  logic                  busy_q;
  logic                  is_rd_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [BW-1:0]         bit_q;
  logic [DATA_W-1:0]     cap_q;
  logic                  last_bit;

  assign last_bit  = (bit_q == BW'(LAST));
  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && last_bit;
  assign done_rd_o = is_rd_q;
  assign cap_o     = cap_q;
  assign mdio_o    = frame_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q && !(is_rd_q && (bit_q >= BW'(TA_POS)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      frame_q <= '0;
      bit_q   <= '0;
      cap_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        is_rd_q <= cmd_i.is_read;
        frame_q <= build_frame(cmd_i, wval_i);
        bit_q   <= '0;
      end
    end else begin
      if (rise_i && is_rd_q && (bit_q >= BW'(DATA_POS)))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          bit_q   <= bit_q + 1'b1;
          frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  // R6: a frame only ends on a falling management clock edge
  assert_busy_ends_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(fall_i)) else $error("frame ended off a falling edge");

  // R5: a start request during a frame does not move the bit position
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !fall_i) |=> $stable(bit_q)) else $error("frame restarted");

  // R10: line released whenever no frame runs
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !mdio_oe_o) else $error("line driven after frame");
endmodule

// File: rtl/mdio_reg_window.sv
module mdio_reg_window
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              done_rd_i,
  input  logic [DATA_W-1:0] cap_i,
  output logic              start_o,
  output mdio_cmd_t         cmd_o,
  output logic [DATA_W-1:0] wval_o
);
  mdio_cmd_t         cmd_q;
  logic [DATA_W-1:0] wval_q;
  logic [DATA_W-1:0] rval_q;
  logic              en_q;
  win_idx_e          idx;

  assign idx     = win_idx_e'(bus_addr);
  assign cmd_o   = cmd_q;
  assign wval_o  = wval_q;
  assign start_o = bus_wr_en && (idx == WIN_CTRL) &&
                   bus_wdata[CTRL_GO_BIT] && bus_wdata[CTRL_EN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      wval_q <= '0;
      rval_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (bus_wr_en) begin
        case (idx)
          WIN_TARGET: cmd_q  <= mdio_cmd_t'(bus_wdata[CMD_W-1:0]);
          WIN_WVAL:   wval_q <= bus_wdata[DATA_W-1:0];
          WIN_CTRL:   en_q   <= bus_wdata[CTRL_EN_BIT];
          default:    ;
        endcase
      end
      if (done_i && done_rd_i) rval_q <= cap_i;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      WIN_TARGET: bus_rdata[CMD_W-1:0]  = cmd_q;
      WIN_WVAL:   bus_rdata[DATA_W-1:0] = wval_q;
      WIN_RVAL:   bus_rdata[DATA_W-1:0] = rval_q;
      WIN_CTRL: begin
        bus_rdata[CTRL_GO_BIT] = busy_i;
        bus_rdata[CTRL_EN_BIT] = en_q;
      end
      default: ;
    endcase
  end

  // R4: a frame can only begin while the interface is enabled
  assert_start_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> en_q) else $error("frame began while disabled");

  // R10: read value holds unless a read frame completes
  assert_rval_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_i && done_rd_i) |=> $stable(rval_q)) else $error("read value moved");
endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic              busy, done, done_rd, start, rise, fall;
  logic [DATA_W-1:0] cap, wval;
  mdio_cmd_t         cmd;

  mdio_reg_window u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy), .done_i(done),
    .done_rd_i(done_rd), .cap_i(cap), .start_o(start), .cmd_o(cmd), .wval_o(wval)
  );

  mdio_clk_div #(.CLK_HALF(CLK_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .wval_i(wval),
    .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i), .busy_o(busy), .done_o(done),
    .done_rd_o(done_rd), .cap_o(cap), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe)
  );
endmodule

// File: tb/mdio_mgmt_top_tb_top.sv
module mdio_mgmt_top_tb_top;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [1:0]  bus_addr = 2'd3;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv_en = 1'b0;
  logic        phy_drv = 1'b1;
  int          tests = 0;
  int          fails = 0;
  int          rises = 0;

  always #5 clk = ~clk;

  // Pull-up on the line, then the master or the PHY model drives it
  assign mdio_i = mdio_oe ? mdio_o : (phy_drv_en ? phy_drv : 1'b1);

  mdio_mgmt_top #(.CLK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural PHY at address 3 ----------------
  localparam logic [4:0] PHY_ID = 5'd3;
  logic [15:0] phy_mem [32];
  int          p_ones = 0;
  int          p_pos = 0;
  bit          p_st0 = 0, p_in = 0, p_rd = 0, p_match = 0;
  logic [11:0] p_hdr = '0;
  logic [15:0] p_dat = '0;

  always @(posedge mdc) begin
    rises++;
    if (!p_in) begin
      if (p_st0) begin
        p_st0 = 0;
        if (mdio_i) begin p_in = 1; p_pos = 34; end
        p_ones = 0;
      end else if (mdio_i) begin
        if (p_ones < 64) p_ones++;
      end else begin
        if (p_ones >= 32) p_st0 = 1;
        p_ones = 0;
      end
    end else begin
      if (p_pos <= 45) p_hdr = {p_hdr[10:0], mdio_i};
      if (p_pos == 45) begin
        p_rd    = (p_hdr[11:10] == 2'b10);
        p_match = (p_hdr[9:5] == PHY_ID);
      end
      if (p_pos >= 48) p_dat = {p_dat[14:0], mdio_i};
      if (p_pos == 63) begin
        if (!p_rd && p_match) phy_mem[p_hdr[4:0]] = p_dat;
        p_in = 0;
      end
      p_pos++;
    end
  end

  always @(negedge mdc) begin
    phy_drv_en = 1'b0;
    if (p_in && p_rd && p_match) begin
      if (p_pos == 47) begin
        phy_drv_en = 1'b1; phy_drv = 1'b0;
      end else if (p_pos >= 48 && p_pos <= 63) begin
        phy_drv_en = 1'b1; phy_drv = phy_mem[p_hdr[4:0]][63-p_pos];
      end
    end
  end

  // ---------------- cycle reference model ----------------
  bit          m_act = 0, m_en = 0, m_mdc = 0, m_rd = 0;
  int          m_cnt = 0, m_bit = 0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  logic [15:0] m_wv = '0, m_cap = '0;
  logic [10:0] m_tgt = '0;
  logic [15:0] m_wreg = '0;

  function automatic bit exp_bit(input int k);
    if (k < 32)  return 1'b1;
    if (k == 32) return 1'b0;
    if (k == 33) return 1'b1;
    if (k == 34) return m_rd;
    if (k == 35) return !m_rd;
    if (k <= 40) return m_phy[40-k];
    if (k <= 45) return m_reg[45-k];
    if (k == 46) return 1'b1;
    if (k == 47) return 1'b0;
    return m_wv[63-k];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_en = 0; m_mdc = 0; m_cnt = 0; m_bit = 0; m_tgt = '0; m_wreg = '0;
    end else begin
      if (m_act) begin
        if (m_cnt == HALF - 1) begin
          m_cnt = 0;
          if (!m_mdc) begin
            m_mdc = 1;
            if (m_rd && m_bit >= 48) m_cap = {m_cap[14:0], mdio_i};
          end else begin
            m_mdc = 0;
            if (m_bit == 63) m_act = 0;
            else m_bit++;
          end
        end else m_cnt++;
      end else if (bus_wr_en && bus_addr == 2'd3 && bus_wdata[0] && bus_wdata[3]) begin
        m_act = 1; m_cnt = 0; m_mdc = 0; m_bit = 0;
        m_rd = m_tgt[10]; m_phy = m_tgt[9:5]; m_reg = m_tgt[4:0]; m_wv = m_wreg;
      end
      if (bus_wr_en) begin
        if (bus_addr == 2'd0) m_tgt = bus_wdata[10:0];
        if (bus_addr == 2'd1) m_wreg = bus_wdata[15:0];
        if (bus_addr == 2'd3) m_en = bus_wdata[3];
      end
    end
  end

  // Per-cycle comparison, R3 busy, R6 clock, R7/R8/R9 line drive
  always @(negedge clk) begin
    if (rst_n) begin
      bit eoe, eo, ok;
      eoe = m_act && !(m_rd && m_bit >= 46);
      eo  = eoe ? exp_bit(m_bit) : 1'b0;
      ok  = (mdc === m_mdc) && (mdio_oe === eoe) && (!eoe || mdio_o === eo) &&
            (bus_addr != 2'd3 || bus_rdata === {28'd0, m_en, 2'b00, m_act});
      check(ok, "R3/R6/R7/R8/R9 cycle",
            {27'd0, mdc, mdio_oe, mdio_o, bus_rdata[3], bus_rdata[0]},
            {27'd0, m_mdc, eoe, eo, m_en, m_act});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #2;
    bus_wr_en = 1'b0; bus_addr = 2'd3; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); #2;
    bus_addr = a; #1; v = bus_rdata; bus_addr = 2'd3;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    @(negedge clk); #1;
    while (bus_rdata[0] && n < 5000) begin n++; @(negedge clk); #1; end
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, r0;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0100 + 16'(i);
    phy_mem[2] = 16'hA5C3;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      check(v == 0, "R1 word after reset", v, 0);
    end
    check(!mdc && !mdio_oe, "R1 pins after reset", {30'd0, mdc, mdio_oe}, 0);

    // R4 start while disabled
    r0 = rises;
    wr(2'd3, 32'h1);
    repeat (6) @(negedge clk);
    rd(2'd3, v);
    check(v == 0, "R4 disabled start", v, 0);
    check(rises == r0, "R4 no mdc edges", rises - r0, 0);

    wr(2'd3, 32'h8);
    rd(2'd3, v);
    check(v == 32'h8, "R3 enable readback", v, 32'h8);

    // R2 / R8 write frame, phy 3 reg 7
    wr(2'd0, 32'h067);
    wr(2'd1, 32'h1234);
    rd(2'd0, v); check(v == 32'h067, "R2 target readback", v, 32'h067);
    rd(2'd1, v); check(v == 32'h1234, "R2 write value readback", v, 32'h1234);
    r0 = rises;
    wr(2'd3, 32'h9);
    wait_idle(n);
    // busy spans 128*HALF cycles; the first busy sample falls inside wr()
    check(n == 128*HALF - 1, "R6 busy length", n, 128*HALF - 1);
    check(rises - r0 == 64, "R6 edges per frame", rises - r0, 64);
    check(phy_mem[7] == 16'h1234, "R8 PHY got write", phy_mem[7], 16'h1234);
    rd(2'd2, v); check(v == 0, "R10 write leaves read value", v, 0);
    rd(2'd3, v); check(v == 32'h8, "R3 status cleared", v, 32'h8);

    // R9 read back reg 7
    wr(2'd0, 32'h467);
    wr(2'd3, 32'h9);
    wait_idle(n);
    rd(2'd2, v); check(v == 32'h1234, "R9 read reg 7", v, 32'h1234);

    // R5 start and retarget during a read of reg 2
    wr(2'd0, 32'h462);
    r0 = rises;
    wr(2'd3, 32'h9);
    repeat (60) @(negedge clk);
    wr(2'd0, 32'h467);
    wr(2'd3, 32'h9);
    wait_idle(n);
    rd(2'd2, v); check(v == 32'hA5C3, "R5 frame kept target", v, 32'hA5C3);
    check(rises - r0 == 64, "R5 no restart", rises - r0, 64);
    rd(2'd0, v); check(v == 32'h467, "R5 target word updated", v, 32'h467);

    // R9 read from an absent PHY: pulled-up line
    wr(2'd0, 32'h522);
    wr(2'd3, 32'h9);
    wait_idle(n);
    rd(2'd2, v); check(v == 32'hFFFF, "R9 undriven line", v, 32'hFFFF);

    // R7/R8 second write pattern, reg 31
    wr(2'd0, 32'h07F);
    wr(2'd1, 32'h8001);
    wr(2'd3, 32'h9);
    wait_idle(n);
    check(phy_mem[31] == 16'h8001, "R7 PHY got write", phy_mem[31], 16'h8001);
    rd(2'd2, v); check(v == 32'hFFFF, "R10 read value held", v, 32'hFFFF);

    repeat (10) @(negedge clk);
    check(!mdc && !mdio_oe, "R10 idle pins", {30'd0, mdc, mdio_oe}, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule